// File: doc/BRIEF.md
# Multi-Channel Variable-Resolution PWM Generator

This block is a bank of independent pulse-width modulators. Each channel drives the enable of an open-drain pull-down output. A channel has three settings. The period is a count of levels N, anywhere from 2 up to 2^CNT_W, and need not be a power of two. The duty is a threshold in levels. The clock divider P stretches every level over P core clocks. One period therefore lasts P × N clocks. A 50 MHz core clock gives about 762 Hz at 65536 levels, and at the other end 25 MHz with two levels and no division.

Configuration enters through one valid/ready write port that carries a channel index, a register select and a data word. The bank never applies back-pressure: `cfg_ready_o` is held high, so a write is taken in every cycle in which `cfg_valid_i` is high. Period, duty and divider writes go into per-channel holding registers. A running channel copies them into its working registers only when its level counter wraps, so every period runs to its full length under one consistent setting. The enable bit takes effect at once.

Top module: `pwm_bank`

## Requirements
- R1: `cfg_ready_o` is always 1 and a write is taken at every rising clock edge with `cfg_valid_i` high. `cfg_sel_i` picks the target register: 0 is the period, holding N−1 in the low CNT_W bits; 1 is the duty D, CNT_W+1 bits; 2 is the divider, holding P−1 in the low PRE_W bits; 3 is control, where bit 0 is the enable.
- R2: An enabled channel's level counter runs from 0 to N−1 and then wraps to 0. One period is exactly P × N clocks for any N from 2 to 2^CNT_W.
- R3: The sink output is 1 (pad pulled low) while the level counter is below D. D = 0 keeps it at 0 for the whole period, and D ≥ N keeps it at 1 for the whole period.
- R4: The level counter advances once every P clocks.
- R5: In the first cycle after the edge that accepts an enabling control write, the output shows level 0. In cycle k after that edge, it shows level (k / P) mod N, using integer division.
- R6: Period, duty and divider writes to a running channel take effect at the first counter wrap strictly after the write edge. The period in progress finishes unchanged.
- R7: A disabled channel keeps its sink output at 0 (pad released) and its counter at 0. Settings written while a channel is disabled are all in force from the moment it is enabled.
- R8: A period register value of 0 is treated as 1, which gives two levels.
- R9: Channels do not affect one another. A write whose channel index is NUM_CH or higher changes no channel.
- R10: After reset, every channel is disabled with its sink output at 0. The holding registers start at period 1 (N = 2), duty 0 and divider 0 (P = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_valid_i | input | 1 | Configuration write request |
| cfg_ready_o | output | 1 | Write accepted; constantly 1 |
| cfg_chan_i | input | CH_W | Target channel index |
| cfg_sel_i | input | 2 | Register select (0 period, 1 duty, 2 divider, 3 control) |
| cfg_data_i | input | CNT_W+1 | Write data |
| sink_o | output | NUM_CH | Per-channel pull-down enable, 1 pulls the pad low |

## Verification
The bench builds the bank with NUM_CH = 3, CNT_W = 4 and PRE_W = 2. This small configuration makes it practical to run every period from 2 to 16 levels against every duty from 0 to N+1, with all four divider ratios spread across the three channels, and still finish in a few tens of thousands of cycles. Every output is compared in every cycle with the level predicted by integer arithmetic from the enable time. Holding-register updates are checked against the predicted wrap cycle, and stray writes with channel index 3 have no channel to land on.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  typedef enum logic [1:0] {
    SEL_PERIOD = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PRESC  = 2'd2,
    SEL_CTRL   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/pwm_cfg_decode.sv
module pwm_cfg_decode #(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic [NUM_CH-1:0] wr_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign wr_o[c] = valid_i && (chan_i == CH_W'(c));
  end

  // R9: at most one channel is targeted by any write
  assert_single_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_o));

  // R9: an index beyond the bank reaches no channel
  assert_bad_index_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && int'(chan_i) >= NUM_CH) |-> (wr_o == '0));
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;

  assign tick_o = run_i && (div_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (!run_i)      div_q <= '0;
    else if (tick_o)      div_q <= '0;
    else                  div_q <= div_q + PRE_W'(1);
  end

  // R4: after a step the next step follows at once only with a divide-by-one setting
  assert_step_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_o) |=> (!tick_o || limit_i == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_bank_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  localparam int DATA_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  cfg_sel_e          sel_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sink_o
);
  logic              en_q, en_n;
  logic [CNT_W-1:0]  hold_per_q, hold_per_n, work_per_q, work_per_n;
  logic [DATA_W-1:0] hold_duty_q, hold_duty_n, work_duty_q, work_duty_n;
  logic [PRE_W-1:0]  hold_pre_q, hold_pre_n, work_pre_q, work_pre_n;
  logic [CNT_W-1:0]  lvl_q, lvl_n;
  logic              sink_q, sink_n;
  logic              step, wrap;

  pwm_prescaler #(.PRE_W(PRE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (en_q),
    .limit_i(work_pre_q),
    .tick_o (step)
  );

  assign wrap = step && (lvl_q == work_per_q);

  always_comb begin
    en_n        = en_q;
    hold_per_n  = hold_per_q;
    hold_duty_n = hold_duty_q;
    hold_pre_n  = hold_pre_q;
    if (wr_i) begin
      unique case (sel_i)
        SEL_PERIOD: hold_per_n  = (data_i[CNT_W-1:0] == '0) ? CNT_W'(1) : data_i[CNT_W-1:0];
        SEL_DUTY:   hold_duty_n = data_i;
        SEL_PRESC:  hold_pre_n  = data_i[PRE_W-1:0];
        SEL_CTRL:   en_n        = data_i[0];
        default:    en_n        = en_q;
      endcase
    end

    work_per_n  = work_per_q;
    work_duty_n = work_duty_q;
    work_pre_n  = work_pre_q;
    lvl_n       = lvl_q;
    if (!en_q || wrap) begin
      work_per_n  = hold_per_q;
      work_duty_n = hold_duty_q;
      work_pre_n  = hold_pre_q;
      lvl_n       = '0;
    end else if (step) begin
      lvl_n = lvl_q + CNT_W'(1);
    end
    if (!en_n) lvl_n = '0;

    sink_n = en_n && ({1'b0, lvl_n} < work_duty_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      hold_per_q  <= CNT_W'(1);
      hold_duty_q <= '0;
      hold_pre_q  <= '0;
      work_per_q  <= CNT_W'(1);
      work_duty_q <= '0;
      work_pre_q  <= '0;
      lvl_q       <= '0;
      sink_q      <= 1'b0;
    end else begin
      en_q        <= en_n;
      hold_per_q  <= hold_per_n;
      hold_duty_q <= hold_duty_n;
      hold_pre_q  <= hold_pre_n;
      work_per_q  <= work_per_n;
      work_duty_q <= work_duty_n;
      work_pre_q  <= work_pre_n;
      lvl_q       <= lvl_n;
      sink_q      <= sink_n;
    end
  end

  assign sink_o = sink_q;

  // R7: a disabled channel never pulls its pad low
  assert_off_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !sink_q);

  // R7: a disabled channel holds its level counter at zero
  assert_off_level_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (lvl_q == '0));

  // R2: the level counter never passes the working period limit
  assert_level_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= work_per_q);

  // R6: working settings change only at a wrap while running
  assert_settings_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !wrap) |=> ($stable(work_duty_q) && $stable(work_per_q) && $stable(work_pre_q)));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int DATA_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  output logic              cfg_ready_o,
  input  logic [CH_W-1:0]   cfg_chan_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic [NUM_CH-1:0] sink_o
);
  logic [NUM_CH-1:0] wr;
  cfg_sel_e          sel;

  assign cfg_ready_o = 1'b1;
  assign sel         = cfg_sel_e'(cfg_sel_i);

  pwm_cfg_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(cfg_valid_i),
    .chan_i (cfg_chan_i),
    .wr_o   (wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr[c]),
      .sel_i (sel),
      .data_i(cfg_data_i),
      .sink_o(sink_o[c])
    );
  end
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int NCH = 3;
  localparam int CW  = 4;
  localparam int PW  = 2;
  localparam int DW  = CW + 1;
  localparam int CHW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_valid = 1'b0;
  logic           cfg_ready;
  logic [CHW-1:0] cfg_chan = '0;
  logic [1:0]     cfg_sel = '0;
  logic [DW-1:0]  cfg_data = '0;
  logic [NCH-1:0] sink;

  pwm_bank #(.NUM_CH(NCH), .CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready),
    .cfg_chan_i(cfg_chan), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data), .sink_o(sink)
  );

  always #5 clk = ~clk;

  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    chk_en = 1'b0;
  bit    done = 1'b0;
  string tag = "R10";
  int    st[NCH], n[NCH], d[NCH], p[NCH], sw[NCH], nn[NCH], nd[NCH], np[NCH];
  bit    on[NCH];

  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle expectation: level = ((cycles since enable) / P) mod N, active when below D
  always @(negedge clk) begin
    if (chk_en) begin
      for (int c = 0; c < NCH; c++) begin
        bit e;
        if (on[c] && sw[c] >= 0 && cyc >= sw[c]) begin
          st[c] = sw[c]; n[c] = nn[c]; d[c] = nd[c]; p[c] = np[c]; sw[c] = -1;
        end
        e = on[c] ? ((((cyc - st[c]) / p[c]) % n[c]) < d[c]) : 1'b0;
        checks++;
        if (sink[c] !== e) begin
          fails++;
          $display("FAIL %s ch%0d cyc=%0d actual=%0b expected=%0b", tag, c, cyc, sink[c], e);
        end
      end
    end
  end

  task automatic wr(input int c, input int sel, input int data);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_chan = CHW'(c); cfg_sel = 2'(sel); cfg_data = DW'(data);
    @(posedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic cfg_off(input int c, input int preg, input int dv, input int pv);
    wr(c, 0, preg); wr(c, 1, dv); wr(c, 2, pv - 1);
    n[c] = (preg == 0) ? 2 : preg + 1; d[c] = dv; p[c] = pv;
  endtask

  task automatic en(input int c);
    wr(c, 3, 1); on[c] = 1'b1; st[c] = cyc; sw[c] = -1;
  endtask

  task automatic dis(input int c);
    wr(c, 3, 0); on[c] = 1'b0; sw[c] = -1;
  endtask

  // live write on a running channel: lands at the first wrap after the write edge (R6)
  task automatic live(input int c, input int sel, input int val);
    int k, pn;
    nn[c] = n[c]; nd[c] = d[c]; np[c] = p[c];
    if (sel == 0) nn[c] = (val == 0) ? 2 : val + 1;
    else if (sel == 1) nd[c] = val;
    else np[c] = val + 1;
    wr(c, sel, val);
    k = cyc - st[c]; pn = p[c] * n[c];
    sw[c] = st[c] + (k / pn + 1) * pn;
  endtask

  task automatic run(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check_bit(input string r, input logic act, input logic exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", r, act, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      on[c] = 1'b0; n[c] = 2; d[c] = 0; p[c] = 1; sw[c] = -1; st[c] = 0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check_bit("R10 reset sink", sink[c], 1'b0);
    check_bit("R1 ready high", cfg_ready, 1'b1);
    rst_n = 1'b1;
    chk_en = 1'b1;

    // R10: reset defaults give two levels, duty zero, no division
    tag = "R10";
    en(0); run(8); dis(0);

    // R2 R3 R4 R5: every period, every duty up to N+1, dividers spread over channels
    tag = "R3";
    for (int nv = 2; nv <= 16; nv++) begin
      for (int dv = 0; dv <= nv + 1; dv++) begin
        int mx;
        mx = 0;
        for (int c = 0; c < NCH; c++) begin
          int pv;
          pv = ((nv + dv + c) % 4) + 1;
          cfg_off(c, nv - 1, dv, pv);
          if (2 * pv * nv > mx) mx = 2 * pv * nv;
        end
        for (int c = 0; c < NCH; c++) en(c);
        run(mx + 2);
        for (int c = 0; c < NCH; c++) dis(c);
      end
    end
    tag = "R3";
    cfg_off(0, 15, 31, 1); en(0); run(40); dis(0);

    // R8: period register zero behaves as one
    tag = "R8";
    cfg_off(1, 0, 1, 1); en(1); run(12); dis(1);

    // R6: live duty, period and divider changes on a 10-level channel
    tag = "R6";
    cfg_off(1, 6, 5, 3); en(1);
    cfg_off(0, 9, 3, 2); en(0);
    run(7);
    live(0, 1, 8); run(65);
    live(0, 0, 4); run(50);
    live(0, 2, 0); run(40);
    live(1, 2, 1); run(70);

    // R9: writes beyond the bank leave every channel untouched
    tag = "R9";
    wr(3, 1, 0); wr(3, 3, 0); wr(3, 0, 0); wr(3, 2, 3);
    run(30);

    // R7: disable mid-period, write while off, re-enable, back-to-back off/on
    tag = "R7";
    dis(0); run(10);
    cfg_off(0, 5, 2, 1); run(5);
    en(0); run(20);
    dis(0); en(0); run(20);
    dis(0); dis(1); run(5);

    chk_en = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule